// File: doc/BRIEF.md
# Instruction prefetch queue controller

This block keeps a small first-in first-out store of instruction bytes filled ahead of execution. A bus sequencer issues single-byte code reads on a simple request/acknowledge memory port. It starts a read only while the store has room for the result. The fetch address is the code segment value shifted left by four bits plus a 16-bit fetch offset. The offset steps by one for every byte kept.

The execution side shares the same bus through a request/grant pair. A code read that has already started always runs to its acknowledge. At every point where the bus could be handed over, a pending execution request wins over a new code read. The grant is held for as long as the request stays high.

A redirect input models a jump or call. It discards every stored byte and loads a new fetch offset, and fetching resumes from the new target. A code read still on the bus when the redirect arrives finishes its bus cycle, but its byte is thrown away. Bytes leave through a valid/ready pop port, and the current fill level is an output.

Top module: `fetch_queue_ctrl`

## Requirements
- R1: While reset is asserted, level_o is 0, pop_valid_o is 0, fetch_req_o is 0 and xgnt_o is 0.
- R2: Bytes leave the pop port in the order their acknowledges were accepted. pop_byte_o always shows the oldest stored byte.
- R3: Whenever fetch_req_o is high, level_o is below the depth (6). With no pops, the store settles at 6 and fetch_req_o stays low.
- R4: A code read uses address (code_seg_i * 16 + offset) mod 2^20. The offset rises by one per kept byte, wrapping mod 2^16, and starts at 0 after reset. fetch_addr_o and fetch_req_o hold steady until fetch_ack_i.
- R5: A code read, once started, is never abandoned. xgnt_o is never high together with fetch_req_o.
- R6: If xreq_i is high in a cycle and no code read is left unfinished at its end, xgnt_o is high and fetch_req_o low in the next cycle. Unfinished means fetch_req_o high with fetch_ack_i low.
- R7: A cycle with xreq_i low is followed by a cycle with xgnt_o low.
- R8: pop_valid_o is high exactly when level_o is non-zero. A pop happens on a clock edge with pop_valid_o and pop_ready_i both high. A pop and a push at the same edge leave level_o unchanged.
- R9: A cycle with redirect_i high empties the store: level_o is 0 and pop_valid_o is 0 in the next cycle. Any pop offered in that cycle is ignored. The next code read uses redirect_off_i as its offset.
- R10: A byte acknowledged in the same cycle as a redirect, or for a read that was in flight when a redirect came, is not stored. The fetch offset keeps the redirect target.
- R11: level_o always equals bytes stored minus bytes popped since the last reset or redirect, and never exceeds 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| code_seg_i | input | 16 | Code segment value |
| redirect_i | input | 1 | Flush and restart request |
| redirect_off_i | input | 16 | New fetch offset on redirect |
| fetch_req_o | output | 1 | Code read request |
| fetch_addr_o | output | 20 | Code read address |
| fetch_data_i | input | 8 | Code read data |
| fetch_ack_i | input | 1 | Code read done, data valid |
| xreq_i | input | 1 | Execution-side bus request |
| xgnt_o | output | 1 | Bus granted to execution side |
| pop_valid_o | output | 1 | Oldest byte is valid |
| pop_byte_o | output | 8 | Oldest stored byte |
| pop_ready_i | input | 1 | Consumer takes the byte |
| level_o | output | 3 | Bytes currently stored |

## Verification
A wrong pointer or fill count shows up at the next pop as a byte that does not match its address-derived value, or as level_o drifting from the bench count one cycle after the faulty edge. A stale fetch offset appears at the next code read address. A missed drop after a redirect leaves level_o non-zero one cycle after the late acknowledge. A wrong arbiter state shows as a grant one cycle early or late against the request model.

// File: rtl/fq_pkg.sv
package fq_pkg;
   typedef enum logic [1:0] {
      BUS_IDLE  = 2'd0,
      BUS_FETCH = 2'd1,
      BUS_DATA  = 2'd2
   } bus_state_e;
endpackage

// File: rtl/fq_buffer.sv
module fq_buffer #(
   parameter  int DEPTH  = 6,
   parameter  int DATA_W = 8,
   localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LVL_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              pop_i,
   input  logic              flush_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              valid_o,
   output logic [LVL_W-1:0]  level_o,
   output logic [LVL_W-1:0]  level_nxt_o
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("fq_buffer: DEPTH must be at least 2");
   end

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [PTR_W-1:0]  rd_q, wr_q, rd_inc, wr_inc;
   logic [LVL_W-1:0]  level_q, level_d;
   logic              do_push, do_pop;

   assign do_pop  = pop_i && (level_q != '0) && !flush_i;
   assign do_push = push_i && !flush_i;

   if ((1 << PTR_W) == DEPTH) begin : g_pow2
      assign rd_inc = rd_q + 1'b1;
      assign wr_inc = wr_q + 1'b1;
   end else begin : g_wrap
      assign rd_inc = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      assign wr_inc = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
   end

   always_comb begin
      level_d = level_q;
      if (flush_i) begin
         level_d = '0;
      end else begin
         case ({do_push, do_pop})
            2'b10:   level_d = level_q + 1'b1;
            2'b01:   level_d = level_q - 1'b1;
            default: level_d = level_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q    <= '0;
         wr_q    <= '0;
         level_q <= '0;
      end else begin
         level_q <= level_d;
         if (flush_i) begin
            rd_q <= '0;
            wr_q <= '0;
         end else begin
            if (do_push) wr_q <= wr_inc;
            if (do_pop)  rd_q <= rd_inc;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem_q[wr_q] <= data_i;
   end

   assign rd_data_o   = mem_q[rd_q];
   assign valid_o     = (level_q != '0);
   assign level_o     = level_q;
   assign level_nxt_o = level_d;

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> (level_q < LVL_W'(DEPTH)) || (pop_i && level_q != '0));
   // R8
   pushpop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && pop_i && level_q != '0 && !flush_i) |=> level_q == $past(level_q));
   // R9
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> level_q == '0);
endmodule

// File: rtl/fq_addr_gen.sv
module fq_addr_gen #(
   parameter int SEG_W     = 16,
   parameter int OFF_W     = 16,
   parameter int SEG_SHIFT = 4,
   parameter int ADDR_W    = 20
) (
   input  logic [SEG_W-1:0]  seg_i,
   input  logic [OFF_W-1:0]  off_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int BASE_W = SEG_W + SEG_SHIFT;
   localparam int SUM_W  = (BASE_W > OFF_W) ? BASE_W : OFF_W;

   if (ADDR_W < OFF_W) begin : g_bad_width
      $error("fq_addr_gen: ADDR_W must cover the offset");
   end

   logic [SUM_W-1:0] base, off, sum;

   assign base = SUM_W'(seg_i) << SEG_SHIFT;
   assign off  = SUM_W'(off_i);
   assign sum  = base + off;

   if (ADDR_W == SUM_W) begin : g_exact
      assign addr_o = sum;
   end else if (ADDR_W < SUM_W) begin : g_trunc
      assign addr_o = sum[ADDR_W-1:0];
   end else begin : g_extend
      assign addr_o = ADDR_W'(sum);
   end
endmodule

// File: rtl/fq_bus_seq.sv
module fq_bus_seq
   import fq_pkg::*;
#(
   parameter  int DEPTH = 6,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             xreq_i,
   input  logic             ack_i,
   input  logic             redirect_i,
   input  logic [LVL_W-1:0] level_nxt_i,
   output bus_state_e       state_o,
   output logic             fetch_start_o,
   output logic             push_o,
   output logic             drop_o
);
   bus_state_e state_q, state_d;
   logic       decide, want_fetch, drop_q, fetch_done;

   assign fetch_done = (state_q == BUS_FETCH) && ack_i;
   assign want_fetch = !xreq_i && (level_nxt_i < LVL_W'(DEPTH));

   always_comb begin
      case (state_q)
         BUS_IDLE:  decide = 1'b1;
         BUS_FETCH: decide = ack_i;
         BUS_DATA:  decide = !xreq_i;
         default:   decide = 1'b1;
      endcase
   end

   always_comb begin
      state_d = state_q;
      if (decide) begin
         if (xreq_i)          state_d = BUS_DATA;
         else if (want_fetch) state_d = BUS_FETCH;
         else                 state_d = BUS_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= BUS_IDLE;
         drop_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (fetch_done)
            drop_q <= 1'b0;
         else if (redirect_i && state_q == BUS_FETCH)
            drop_q <= 1'b1;
      end
   end

   assign fetch_start_o = decide && want_fetch;
   assign push_o        = fetch_done && !drop_q && !redirect_i;
   assign drop_o        = drop_q;
   assign state_o       = state_q;

   // R10
   drop_only_in_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drop_q |-> state_q == BUS_FETCH);
endmodule

// File: rtl/fetch_queue_ctrl.sv
module fetch_queue_ctrl
   import fq_pkg::*;
#(
   parameter  int DEPTH     = 6,
   parameter  int DATA_W    = 8,
   parameter  int SEG_W     = 16,
   parameter  int OFF_W     = 16,
   parameter  int SEG_SHIFT = 4,
   parameter  int ADDR_W    = 20,
   localparam int LVL_W     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEG_W-1:0]  code_seg_i,
   input  logic              redirect_i,
   input  logic [OFF_W-1:0]  redirect_off_i,
   output logic              fetch_req_o,
   output logic [ADDR_W-1:0] fetch_addr_o,
   input  logic [DATA_W-1:0] fetch_data_i,
   input  logic              fetch_ack_i,
   input  logic              xreq_i,
   output logic              xgnt_o,
   output logic              pop_valid_o,
   output logic [DATA_W-1:0] pop_byte_o,
   input  logic              pop_ready_i,
   output logic [LVL_W-1:0]  level_o
);
   bus_state_e        state;
   logic              fetch_start, push, drop;
   logic [LVL_W-1:0]  level_nxt;
   logic [OFF_W-1:0]  ip_q, ip_nxt;
   logic [ADDR_W-1:0] addr_q, phys;

   assign ip_nxt = redirect_i ? redirect_off_i :
                   push       ? ip_q + 1'b1    : ip_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ip_q   <= '0;
         addr_q <= '0;
      end else begin
         ip_q <= ip_nxt;
         if (fetch_start) addr_q <= phys;
      end
   end

   fq_addr_gen #(
      .SEG_W(SEG_W), .OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT), .ADDR_W(ADDR_W)
   ) u_addr (
      .seg_i (code_seg_i),
      .off_i (ip_nxt),
      .addr_o(phys)
   );

   fq_bus_seq #(.DEPTH(DEPTH)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .xreq_i       (xreq_i),
      .ack_i        (fetch_ack_i),
      .redirect_i   (redirect_i),
      .level_nxt_i  (level_nxt),
      .state_o      (state),
      .fetch_start_o(fetch_start),
      .push_o       (push),
      .drop_o       (drop)
   );

   fq_buffer #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_i     (push),
      .data_i     (fetch_data_i),
      .pop_i      (pop_ready_i),
      .flush_i    (redirect_i),
      .rd_data_o  (pop_byte_o),
      .valid_o    (pop_valid_o),
      .level_o    (level_o),
      .level_nxt_o(level_nxt)
   );

   assign fetch_req_o  = (state == BUS_FETCH);
   assign xgnt_o       = (state == BUS_DATA);
   assign fetch_addr_o = addr_q;

   // R3
   fetch_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req_o |-> level_o < LVL_W'(DEPTH));
   // R4
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req_o && !fetch_ack_i) |=> $stable(fetch_addr_o));
   // R5
   fetch_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req_o && !fetch_ack_i) |=> fetch_req_o && !xgnt_o);
   // R6
   xreq_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xreq_i && !(fetch_req_o && !fetch_ack_i)) |=> xgnt_o && !fetch_req_o);
   // R7
   gnt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !xreq_i |=> !xgnt_o);
   // R10
   late_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req_o && fetch_ack_i && (redirect_i || drop)) |=> level_o == '0);
   // R11
   level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level_o <= LVL_W'(DEPTH));
endmodule

// File: tb/fetch_queue_ctrl_tb.sv
module fetch_queue_ctrl_tb;
   localparam int DEPTH = 6;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] code_seg_i;
   logic        redirect_i;
   logic [15:0] redirect_off_i;
   logic        fetch_req_o;
   logic [19:0] fetch_addr_o;
   logic [7:0]  fetch_data_i;
   logic        fetch_ack_i;
   logic        xreq_i;
   logic        xgnt_o;
   logic        pop_valid_o;
   logic [7:0]  pop_byte_o;
   logic        pop_ready_i;
   logic [2:0]  level_o;

   always #10 clk = ~clk;

   fetch_queue_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .code_seg_i(code_seg_i),
      .redirect_i(redirect_i), .redirect_off_i(redirect_off_i),
      .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o),
      .fetch_data_i(fetch_data_i), .fetch_ack_i(fetch_ack_i),
      .xreq_i(xreq_i), .xgnt_o(xgnt_o),
      .pop_valid_o(pop_valid_o), .pop_byte_o(pop_byte_o),
      .pop_ready_i(pop_ready_i), .level_o(level_o)
   );

   int tests = 0;
   int fails = 0;
   logic [7:0]  exp_q[$];
   logic [15:0] exp_ip = '0;
   bit          drop_pend = 0;
   int          lat = 0;
   int          wait_cnt = 0;
   bit          pop_en = 0;
   bit          xreq_en = 0;
   bit          gnt_exp = 0;
   bit          redir_req = 0;
   logic [15:0] redir_tgt = '0;
   logic [15:0] redir_seg = '0;
   bit          pp_seen = 0;

   function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
      return {s, 4'h0} + {4'h0, o};
   endfunction

   function automatic logic [7:0] mem_byte(input logic [19:0] a);
      return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'h5A;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one cycle: observe settled outputs, then drive inputs for the next edge
   task automatic step();
      bit redir, acking, popping;
      logic [7:0] e;
      @(negedge clk);
      check(int'(level_o) == exp_q.size(), "R11 level", int'(level_o), exp_q.size());
      check(pop_valid_o == (exp_q.size() != 0), "R8 valid", int'(pop_valid_o), int'(exp_q.size() != 0));
      check(xgnt_o == gnt_exp, xreq_en ? "R6 grant" : "R7 release", int'(xgnt_o), int'(gnt_exp));
      if (fetch_req_o) begin
         check(int'(level_o) < DEPTH, "R3 room", int'(level_o), DEPTH - 1);
         check(!xgnt_o, "R5 exclusive", int'(xgnt_o), 0);
      end
      redir = redir_req;
      redir_req = 0;
      redirect_i = 1'b0;
      fetch_ack_i = 1'b0;
      pop_ready_i = 1'b0;
      acking = 0;
      popping = 0;
      if (!redir && pop_en) begin
         pop_ready_i = 1'b1;
         if (pop_valid_o) begin
            popping = 1;
            if (exp_q.size() == 0) check(0, "R2 order", int'(pop_byte_o), 0);
            else begin
               e = exp_q.pop_front();
               check(pop_byte_o == e, "R2 order", int'(pop_byte_o), int'(e));
            end
         end
      end
      if (fetch_req_o) begin
         if (wait_cnt >= lat) begin
            acking = 1;
            wait_cnt = 0;
            fetch_ack_i = 1'b1;
            fetch_data_i = mem_byte(fetch_addr_o);
            if (drop_pend || redir) begin
               drop_pend = 0;
            end else begin
               check(fetch_addr_o == phys(code_seg_i, exp_ip), "R4 address",
                     int'(fetch_addr_o), int'(phys(code_seg_i, exp_ip)));
               exp_q.push_back(mem_byte(fetch_addr_o));
               exp_ip = exp_ip + 16'd1;
               if (popping) pp_seen = 1;
            end
         end else begin
            wait_cnt++;
         end
      end
      if (redir) begin
         redirect_i = 1'b1;
         redirect_off_i = redir_tgt;
         code_seg_i = redir_seg;
         exp_q.delete();
         exp_ip = redir_tgt;
         if (fetch_req_o && !acking) drop_pend = 1;
      end
      xreq_i = xreq_en;
      gnt_exp = xreq_en && !(fetch_req_o && !acking);
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic wait_fetch();
      for (int i = 0; i < 50; i++) begin
         if (fetch_req_o) break;
         step();
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL R1 watchdog expired actual=%0d expected=0", 1);
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      code_seg_i = '0; redirect_i = 1'b0; redirect_off_i = '0;
      fetch_data_i = '0; fetch_ack_i = 1'b0; xreq_i = 1'b0; pop_ready_i = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(level_o == 3'd0, "R1 level", int'(level_o), 0);
      check(!pop_valid_o, "R1 valid", int'(pop_valid_o), 0);
      check(!fetch_req_o, "R1 fetch_req", int'(fetch_req_o), 0);
      check(!xgnt_o, "R1 grant", int'(xgnt_o), 0);
      rst_n = 1'b1;

      // R3: fill without popping
      lat = 0; pop_en = 0;
      run(20);
      check(int'(level_o) == DEPTH, "R3 full", int'(level_o), DEPTH);
      check(!fetch_req_o, "R3 idle when full", int'(fetch_req_o), 0);

      // R8: stream with pops and pushes together
      pop_en = 1; pp_seen = 0;
      run(25);
      check(pp_seen, "R8 push with pop", int'(pp_seen), 1);

      // R2/R4: slower memory
      lat = 3;
      run(40);
      lat = 1; pop_en = 0;
      run(20);
      pop_en = 1;
      run(10);

      // R5/R6: execution request during an in-flight read
      lat = 4;
      wait_fetch();
      xreq_en = 1;
      run(12);
      xreq_en = 0;
      run(3);   // R7 release checked by step

      // R6: priority from idle with full store
      pop_en = 0; lat = 0;
      run(15);
      xreq_en = 1; pop_en = 1;
      run(2);
      for (int i = 0; i < 5; i++) begin
         step();
         check(!fetch_req_o, "R6 no prefetch", int'(fetch_req_o), 0);
      end
      xreq_en = 0;
      run(10);

      // R9: redirect with a full store
      pop_en = 0;
      run(15);
      redir_seg = 16'h1234; redir_tgt = 16'h0F00; redir_req = 1;
      step();
      step();
      check(level_o == 3'd0 && !pop_valid_o, "R9 flush", int'(level_o), 0);
      check(fetch_addr_o == 20'h13240, "R4 target address", int'(fetch_addr_o), 'h13240);
      pop_en = 1;
      run(10);

      // R10: redirect while a slow read is on the bus
      lat = 5;
      wait_fetch();
      step();
      redir_seg = 16'h0200; redir_tgt = 16'h2000; redir_req = 1;
      run(25);

      // R10: redirect in the same cycle as an acknowledge
      lat = 0;
      wait_fetch();
      redir_seg = 16'h0300; redir_tgt = 16'h0040; redir_req = 1;
      run(12);

      // R4: offset and address wrap
      pop_en = 0;
      redir_seg = 16'hFFFF; redir_tgt = 16'hFFFE; redir_req = 1;
      run(12);
      check(int'(level_o) == DEPTH, "R4 wrap fill", int'(level_o), DEPTH);
      pop_en = 1;
      run(10);

      summary();
      $finish;
   end
endmodule